// File: doc/BRIEF.md
# Timer Interrupt Router

This block sits between a bank of timer channels and the interrupt lines of a chip. Each channel reports a match as a one-cycle pulse. The router then raises the interrupt line that the channel's route field selects. A channel in level mode latches its event into a status bit, and the line stays asserted until software clears that bit. A channel in edge mode produces a single one-clock pulse on its line. The high-numbered lines are active-low: they rest high and are pulled low when asserted. The router applies this inversion itself, so every channel sees the same active-high meaning of "asserted".

Two external interrupt sources, a periodic-tick input and a real-time-clock input, normally pass straight through to line 0 and line 8. When the legacy replacement bit is set, channel 0 takes over line 0 and channel 1 takes over line 8, whatever their route fields say. In that mode both external inputs are cut off, and an enable output tells the periodic-tick source that it is not needed. The real-time-clock level is still recorded during legacy mode. When legacy mode ends, line 8 shows that recorded level again.

Top module: `tmr_irq_router`

## Requirements
- R1: While reset is held, and on the cycle after it is released, every line below 16 is 0 and every line at index 16 or above is 1 (idle). All status bits are 0, `tick_en_o` is 1 and the recorded clock level is 0.
- R2: In level mode (`ch_level_i` bit = 1) a match on an enabled channel, with the global enable set, sets the channel's status bit one cycle after the match. It asserts the routed line two cycles after the match. The line stays asserted for as long as the status bit is set.
- R3: A clear strobe drops the status bit after one cycle and the line after two. When a clear and a match arrive in the same cycle, the match wins and the status bit stays set.
- R4: In edge mode (`ch_level_i` bit = 0) a match produces exactly one asserted cycle on the routed line, two cycles after the match, and leaves the status bit at 0.
- R5: A line with index 16 or above is active-low: it idles at 1 and reads 0 while asserted, in both level and edge mode.
- R6: Clearing a channel's enable or the global enable deasserts its line one cycle later, and the status bit is kept. Setting the enable again re-asserts the line. A match arriving while the channel is disabled sets nothing.
- R7: With `legacy_i` = 1, channel 0 drives line 0 and channel 1 drives line 8, and their route fields are ignored. The other channels keep their route fields.
- R8: With `legacy_i` = 0, `tick_irq_i` reaches line 0 and `clk_irq_i` reaches line 8, each two cycles after the input. Each is ORed with any channel routed to the same line.
- R9: With `legacy_i` = 1, `tick_irq_i` and `clk_irq_i` have no effect on any line, and `tick_en_o` is 0 one cycle after `legacy_i` rises.
- R10: One cycle after `legacy_i` falls, `tick_en_o` is 1, line 0 is released and line 8 shows the clock level recorded while legacy mode was active.
- R11: A channel whose route value is 24 or more (no such line) asserts no line, though its status bit still works.
- R12: When two asserted channels share a line, the line stays asserted until both are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| glb_en_i | input | 1 | Global interrupt enable |
| legacy_i | input | 1 | Legacy replacement mode |
| ch_en_i | input | NCH | Per-channel interrupt enable |
| ch_level_i | input | NCH | Per-channel trigger type, 1 = level, 0 = edge |
| ch_route_i | input | NCH*RW | Per-channel line number, channel c in bits [c*RW +: RW] |
| match_i | input | NCH | Per-channel match pulse |
| clr_i | input | NCH | Per-channel status clear strobe |
| tick_irq_i | input | 1 | External periodic-tick interrupt level |
| clk_irq_i | input | 1 | External real-time-clock interrupt level |
| irq_o | output | NLINE | Interrupt lines, index 16 and up active-low |
| tick_en_o | output | 1 | Periodic-tick source enable, low in legacy mode |
| sts_o | output | NCH | Level-mode status bits |

## Verification
The hardest situation to reach from the ports is leaving legacy mode. At that moment line 8 must show a clock level that was recorded while the input had no visible effect. The stimulus first raises `clk_irq_i` inside legacy mode and confirms that every line stays idle. It then drops `legacy_i` while the input is still high and expects line 8 to assert on the very next cycle. Finally it lowers the input and expects the pass-through delay of two cycles. The coincident clear-and-match case is driven on the same clock edge, so the priority between the two is observed directly.

// File: rtl/tmr_irq_pkg.sv
`timescale 1ns/1ps
package tmr_irq_pkg;

  // Trigger type of one channel.
  typedef enum logic {
    TRIG_EDGE  = 1'b0,
    TRIG_LEVEL = 1'b1
  } trig_e;

  // Mask of the lines that are active-low (index >= base, below n).
  // Only the low n bits are meaningful; n is limited to 64.
  function automatic logic [63:0] inv_mask(input int n, input int base);
    logic [63:0] m;
    m = '0;
    for (int i = 0; i < 64; i++) begin
      if (i < n && i >= base) m[i] = 1'b1;
    end
    return m;
  endfunction

endpackage

// File: rtl/tmr_irq_chan.sv
`timescale 1ns/1ps
module tmr_irq_chan
  import tmr_irq_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  match_i,
  input  logic  clr_i,
  input  logic  en_i,
  input  logic  glb_en_i,
  input  trig_e trig_i,
  output logic  active_o,
  output logic  sts_o
);

  logic armed;
  logic sts_q;
  logic pulse_q;

  assign armed = en_i & glb_en_i;

  // A new event has priority over a clear arriving in the same cycle.
  always_ff @(posedge clk) begin
    if (rst) begin
      sts_q   <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      if (match_i && armed && trig_i == TRIG_LEVEL) begin
        sts_q <= 1'b1;
      end else if (clr_i) begin
        sts_q <= 1'b0;
      end
      pulse_q <= match_i && armed && trig_i == TRIG_EDGE;
    end
  end

  // Logical (active-high) request towards the crossbar.
  always_comb begin
    if (trig_i == TRIG_LEVEL) active_o = sts_q & armed;
    else                      active_o = pulse_q & armed;
  end

  assign sts_o = sts_q;

  // R2
  sts_hold_chk: assert property (@(posedge clk) disable iff (rst)
    sts_q && !clr_i |=> sts_q);

  // R3
  sts_clear_chk: assert property (@(posedge clk) disable iff (rst)
    clr_i && !match_i |=> !sts_q);

  // R4
  edge_nosts_chk: assert property (@(posedge clk) disable iff (rst)
    !sts_q && trig_i == TRIG_EDGE |=> !sts_q);

endmodule

// File: rtl/tmr_irq_legacy.sv
`timescale 1ns/1ps
module tmr_irq_legacy (
  input  logic clk,
  input  logic rst,
  input  logic legacy_i,
  input  logic tick_i,
  input  logic rtc_i,
  output logic tick_line_o,
  output logic rtc_line_o,
  output logic tick_en_o
);

  logic tick_q;
  logic rtc_q;
  logic tick_en_q;

  // The clock level is recorded in every mode so that it can be shown
  // again on its line as soon as legacy replacement ends.
  always_ff @(posedge clk) begin
    if (rst) begin
      tick_q    <= 1'b0;
      rtc_q     <= 1'b0;
      tick_en_q <= 1'b1;
    end else begin
      tick_q    <= tick_i;
      rtc_q     <= rtc_i;
      tick_en_q <= ~legacy_i;
    end
  end

  assign tick_line_o = tick_q & ~legacy_i;
  assign rtc_line_o  = rtc_q  & ~legacy_i;
  assign tick_en_o   = tick_en_q;

endmodule

// File: rtl/tmr_irq_xbar.sv
`timescale 1ns/1ps
module tmr_irq_xbar
  import tmr_irq_pkg::*;
#(
  parameter int NCH      = 4,
  parameter int NLINE    = 24,
  parameter int RW       = 5,
  parameter int INV_BASE = 16,
  parameter int LEG0     = 0,
  parameter int LEG1     = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              legacy_i,
  input  logic [NCH-1:0]    active_i,
  input  logic [NCH*RW-1:0] route_i,
  input  logic              tick_line_i,
  input  logic              rtc_line_i,
  output logic [NLINE-1:0]  irq_o
);

  localparam logic [NLINE-1:0] IDLE = NLINE'(inv_mask(NLINE, INV_BASE));

  logic [NCH-1:0][RW-1:0] eff;
  logic [NLINE-1:0]       want;
  logic [NLINE-1:0]       irq_q;

  // Effective route: legacy replacement overrides channels 0 and 1.
  for (genvar c = 0; c < NCH; c++) begin : g_ch
    if (c == 0) begin : g_leg0
      assign eff[c] = legacy_i ? RW'(LEG0) : route_i[c*RW +: RW];
    end else if (c == 1) begin : g_leg1
      assign eff[c] = legacy_i ? RW'(LEG1) : route_i[c*RW +: RW];
    end else begin : g_plain
      assign eff[c] = route_i[c*RW +: RW];
    end
  end

  // Per line: OR of all channels routed here, plus an external source.
  for (genvar l = 0; l < NLINE; l++) begin : g_line
    localparam logic [RW-1:0] LID = RW'(l);
    logic [NCH-1:0] hit;
    logic           ext;
    for (genvar c = 0; c < NCH; c++) begin : g_hit
      assign hit[c] = active_i[c] & (eff[c] == LID);
    end
    if (l == LEG0) begin : g_ext_tick
      assign ext = tick_line_i;
    end else if (l == LEG1) begin : g_ext_rtc
      assign ext = rtc_line_i;
    end else begin : g_ext_none
      assign ext = 1'b0;
    end
    assign want[l] = (|hit) | ext;
  end

  // Polarity folding happens just before the output register.
  always_ff @(posedge clk) begin
    if (rst) irq_q <= IDLE;
    else     irq_q <= want ^ IDLE;
  end

  assign irq_o = irq_q;

endmodule

// File: rtl/tmr_irq_router.sv
`timescale 1ns/1ps
module tmr_irq_router
  import tmr_irq_pkg::*;
#(
  parameter int NCH       = 4,
  parameter int NLINE     = 24,
  parameter int INV_BASE  = 16,
  parameter int LEG0_LINE = 0,
  parameter int LEG1_LINE = 8,
  localparam int RW       = $clog2(NLINE)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              glb_en_i,
  input  logic              legacy_i,
  input  logic [NCH-1:0]    ch_en_i,
  input  logic [NCH-1:0]    ch_level_i,
  input  logic [NCH*RW-1:0] ch_route_i,
  input  logic [NCH-1:0]    match_i,
  input  logic [NCH-1:0]    clr_i,
  input  logic              tick_irq_i,
  input  logic              clk_irq_i,
  output logic [NLINE-1:0]  irq_o,
  output logic              tick_en_o,
  output logic [NCH-1:0]    sts_o
);

  localparam logic [NLINE-1:0] IDLE = NLINE'(inv_mask(NLINE, INV_BASE));

  logic [NCH-1:0] active;
  logic           tick_line;
  logic           rtc_line;

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    tmr_irq_chan u_chan (
      .clk      (clk),
      .rst      (rst),
      .match_i  (match_i[c]),
      .clr_i    (clr_i[c]),
      .en_i     (ch_en_i[c]),
      .glb_en_i (glb_en_i),
      .trig_i   (trig_e'(ch_level_i[c])),
      .active_o (active[c]),
      .sts_o    (sts_o[c])
    );
  end

  tmr_irq_legacy u_legacy (
    .clk         (clk),
    .rst         (rst),
    .legacy_i    (legacy_i),
    .tick_i      (tick_irq_i),
    .rtc_i       (clk_irq_i),
    .tick_line_o (tick_line),
    .rtc_line_o  (rtc_line),
    .tick_en_o   (tick_en_o)
  );

  tmr_irq_xbar #(
    .NCH      (NCH),
    .NLINE    (NLINE),
    .RW       (RW),
    .INV_BASE (INV_BASE),
    .LEG0     (LEG0_LINE),
    .LEG1     (LEG1_LINE)
  ) u_xbar (
    .clk         (clk),
    .rst         (rst),
    .legacy_i    (legacy_i),
    .active_i    (active),
    .route_i     (ch_route_i),
    .tick_line_i (tick_line),
    .rtc_line_i  (rtc_line),
    .irq_o       (irq_o)
  );

  // R6
  idle_when_off_chk: assert property (@(posedge clk) disable iff (rst)
    legacy_i && !glb_en_i |=> irq_o == IDLE);

endmodule

// File: tb/sim_tmr_irq_router.sv
`timescale 1ns/1ps
module sim_tmr_irq_router;

  localparam int NCH   = 4;
  localparam int NLINE = 24;
  localparam int RW    = $clog2(NLINE);
  localparam logic [NLINE-1:0] IDLE = 24'hFF0000;

  logic clk = 1'b0;
  logic rst;
  logic glb_en, legacy, tick, rtcin;
  logic [NCH-1:0] ch_en, ch_lvl, match, clr;
  logic [NCH*RW-1:0] route;
  logic [NLINE-1:0] irq;
  logic tick_en;
  logic [NCH-1:0] sts;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  tmr_irq_router u0 (
    .clk(clk), .rst(rst), .glb_en_i(glb_en), .legacy_i(legacy),
    .ch_en_i(ch_en), .ch_level_i(ch_lvl), .ch_route_i(route),
    .match_i(match), .clr_i(clr), .tick_irq_i(tick), .clk_irq_i(rtcin),
    .irq_o(irq), .tick_en_o(tick_en), .sts_o(sts)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_route(input int c, input int r);
    route[c*RW +: RW] = RW'(r);
  endtask

  task automatic pulse_match(input int c);
    match[c] = 1'b1;
    tick_n(1);
    match[c] = 1'b0;
  endtask

  task automatic pulse_clr(input int c);
    clr[c] = 1'b1;
    tick_n(1);
    clr[c] = 1'b0;
  endtask

  task automatic t_reset;
    rst = 1'b1; glb_en = 0; legacy = 0; tick = 0; rtcin = 0;
    ch_en = '0; ch_lvl = '0; match = '0; clr = '0; route = '0;
    tick_n(3);
    chk("R1 lines in reset", int'(irq), int'(IDLE));
    chk("R1 tick enable in reset", int'(tick_en), 1);
    rst = 1'b0;
    tick_n(1);
    chk("R1 lines after reset", int'(irq), int'(IDLE));
    chk("R1 status after reset", int'(sts), 0);
    chk("R1 tick enable after reset", int'(tick_en), 1);
    glb_en = 1'b1; ch_en = '1;
    tick_n(1);
  endtask

  task automatic t_level;
    ch_lvl[2] = 1'b1; set_route(2, 5);
    tick_n(1);
    pulse_match(2);
    chk("R2 status set", int'(sts[2]), 1);
    chk("R2 line not yet", int'(irq[5]), 0);
    tick_n(1);
    chk("R2 line asserted", int'(irq[5]), 1);
    tick_n(3);
    chk("R2 line held", int'(irq[5]), 1);
    pulse_clr(2);
    chk("R3 status cleared", int'(sts[2]), 0);
    tick_n(1);
    chk("R3 line dropped", int'(irq[5]), 0);
    match[2] = 1'b1; clr[2] = 1'b1;
    tick_n(1);
    match[2] = 1'b0; clr[2] = 1'b0;
    chk("R3 match beats clear", int'(sts[2]), 1);
    tick_n(1);
    chk("R3 line after tie", int'(irq[5]), 1);
    pulse_clr(2);
    tick_n(1);
  endtask

  task automatic t_edge;
    ch_lvl[3] = 1'b0; set_route(3, 6);
    tick_n(1);
    pulse_match(3);
    chk("R4 edge not yet", int'(irq[6]), 0);
    tick_n(1);
    chk("R4 edge pulse", int'(irq[6]), 1);
    chk("R4 edge no status", int'(sts[3]), 0);
    tick_n(1);
    chk("R4 edge single cycle", int'(irq[6]), 0);
  endtask

  task automatic t_polarity;
    set_route(2, 20);
    tick_n(1);
    chk("R5 idle high", int'(irq[20]), 1);
    pulse_match(2);
    tick_n(1);
    chk("R5 level asserted low", int'(irq[20]), 0);
    pulse_clr(2);
    tick_n(1);
    chk("R5 level released high", int'(irq[20]), 1);
    set_route(3, 17);
    tick_n(1);
    pulse_match(3);
    tick_n(1);
    chk("R5 edge low pulse", int'(irq[17]), 0);
    tick_n(1);
    chk("R5 edge back high", int'(irq[17]), 1);
  endtask

  task automatic t_mask;
    set_route(2, 5);
    pulse_match(2);
    tick_n(1);
    chk("R6 line up before mask", int'(irq[5]), 1);
    ch_en[2] = 1'b0;
    tick_n(1);
    chk("R6 channel disable drops line", int'(irq[5]), 0);
    chk("R6 status kept", int'(sts[2]), 1);
    ch_en[2] = 1'b1;
    tick_n(1);
    chk("R6 re-enable restores line", int'(irq[5]), 1);
    glb_en = 1'b0;
    tick_n(1);
    chk("R6 global disable drops line", int'(irq[5]), 0);
    glb_en = 1'b1;
    pulse_clr(2);
    tick_n(1);
    ch_en[2] = 1'b0;
    pulse_match(2);
    tick_n(1);
    chk("R6 match while disabled", int'(sts[2]), 0);
    chk("R6 lines idle while disabled", int'(irq), int'(IDLE));
    ch_en[2] = 1'b1;
    tick_n(1);
    chk("R6 nothing latched", int'(irq), int'(IDLE));
  endtask

  task automatic t_legacy;
    set_route(0, 3); set_route(1, 4); ch_lvl[1:0] = 2'b11;
    legacy = 1'b1;
    tick_n(1);
    chk("R9 tick enable low", int'(tick_en), 0);
    chk("R9 lines idle", int'(irq), int'(IDLE));
    pulse_match(0);
    tick_n(1);
    chk("R7 ch0 on line 0", int'(irq[0]), 1);
    chk("R7 ch0 route ignored", int'(irq[3]), 0);
    pulse_match(1);
    tick_n(1);
    chk("R7 ch1 on line 8", int'(irq[8]), 1);
    chk("R7 ch1 route ignored", int'(irq[4]), 0);
    pulse_match(2);
    tick_n(1);
    chk("R7 ch2 keeps route", int'(irq[5]), 1);
    clr = 4'b0111;
    tick_n(1);
    clr = '0;
    tick_n(1);
    chk("R7 all cleared", int'(irq), int'(IDLE));
    tick = 1'b1; rtcin = 1'b1;
    tick_n(3);
    chk("R9 external inputs suppressed", int'(irq), int'(IDLE));
    tick = 1'b0;
    tick_n(2);
  endtask

  task automatic t_leave;
    legacy = 1'b0;
    tick_n(1);
    chk("R10 tick enable high", int'(tick_en), 1);
    chk("R10 line 8 restored", int'(irq[8]), 1);
    chk("R10 line 0 released", int'(irq[0]), 0);
    rtcin = 1'b0;
    tick_n(1);
    chk("R8 clock delay", int'(irq[8]), 1);
    tick_n(1);
    chk("R8 clock follows", int'(irq[8]), 0);
  endtask

  task automatic t_pass;
    tick = 1'b1;
    tick_n(1);
    chk("R8 tick delay", int'(irq[0]), 0);
    tick_n(1);
    chk("R8 tick passes", int'(irq[0]), 1);
    tick = 1'b0;
    tick_n(2);
    chk("R8 tick released", int'(irq[0]), 0);
    set_route(2, 8);
    pulse_match(2);
    tick_n(1);
    chk("R8 channel shares line 8", int'(irq[8]), 1);
    pulse_clr(2);
    tick_n(1);
    chk("R8 line 8 released", int'(irq[8]), 0);
  endtask

  task automatic t_share;
    set_route(2, 5); set_route(3, 5); ch_lvl[3] = 1'b1;
    match = 4'b1100;
    tick_n(1);
    match = '0;
    tick_n(1);
    chk("R12 shared line up", int'(irq[5]), 1);
    pulse_clr(2);
    tick_n(1);
    chk("R12 one source left", int'(irq[5]), 1);
    pulse_clr(3);
    tick_n(1);
    chk("R12 both cleared", int'(irq[5]), 0);
  endtask

  task automatic t_oob;
    set_route(2, 30);
    pulse_match(2);
    chk("R11 status still set", int'(sts[2]), 1);
    tick_n(1);
    chk("R11 no line driven", int'(irq), int'(IDLE));
    pulse_clr(2);
    tick_n(1);
  endtask

  initial begin
    t_reset();
    t_level();
    t_edge();
    t_polarity();
    t_mask();
    t_legacy();
    t_leave();
    t_pass();
    t_share();
    t_oob();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule